// File: doc/BRIEF.md
# CPU Bus-Grant Fetch Sequencer

This block is the control sequencer of a small processor, stepping through three fetch states, a decode state and an execute state, extended so that an external DMA master can take over the system bus. A bus request from the master is looked at only in the first fetch state. That state is reached only after the previous instruction has completed execution. There the sequencer loads a registered grant flag with the request. It then stays in that first fetch state for as long as the request is held high. While it waits, none of that state's micro-operations are carried out.

The grant flag drives the output enables of the processor's bus drivers. It goes directly to the enables of the 16 address lines and of every control line. It also disables the data drivers whatever the read/write direction. Execution length is left abstract: the execute state lasts until an instruction-done input is high. Datapath behaviour beyond the state code and a strobe marking the first fetch micro-operations is not modelled.

Top module: `busgrant_sequencer`

## Requirements
- R1: While reset is asserted and right after it, the state code is 0 (first fetch), the grant is 0 and every address and control enable is 1.
- R2: In state 0 with the bus request at 1, the next clock edge sets the grant to 1 and leaves the state code at 0.
- R3: In state 0 with the request at 1, the fetch strobe `fetch_uop_o` is 0, and the state stays 0 on every edge while the request is held.
- R4: In state 0 with the request at 0, the fetch strobe is 1 in that cycle, and the next edge clears the grant and moves to state code 1.
- R5: From state code 1 the sequencer advances one code per clock: 1, then 2, then 3 (decode), then 4 (execute).
- R6: State 4 is held while `exec_done_i` is 0; on an edge with `exec_done_i` at 1 the state returns to 0.
- R7: A request raised in states 1 to 4 is ignored: the grant stays 0 and the state advances normally until state 0 is reached.
- R8: The grant is registered: a change of the request between clock edges does not change the grant before the next edge.
- R9: Every bit of `addr_oe_o` and of `ctrl_oe_o` is 1 when the grant is 0 and 0 when the grant is 1.
- R10: `data_oe_o` equals `mem_wr_i` when the grant is 0 and is 0 whenever the grant is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req_i | input | 1 | Bus request from the DMA master |
| exec_done_i | input | 1 | Current instruction has finished executing |
| mem_wr_i | input | 1 | Datapath wants to drive the data bus (write) |
| bus_grant_o | output | 1 | Registered bus grant to the DMA master |
| state_o | output | 3 | State code: 0/1/2 fetch, 3 decode, 4 execute |
| fetch_uop_o | output | 1 | First-fetch micro-operations happen this cycle |
| addr_oe_o | output | 16 | Per-line enable of the address drivers |
| ctrl_oe_o | output | 4 | Per-line enable of the control drivers |
| data_oe_o | output | 1 | Enable of the data bus drivers |

## Verification
Two functions can land on one clock edge: release of the grant and the start of a new fetch. When the request drops in state 0, the fetch strobe rises in that same cycle, and the following edge clears the grant and leaves state 0 at once. The bench drops the request after a held grant and checks the strobe before that edge, then checks grant, state and enables after it. A second collision occurs when the execute state ends with a request already pending. In that case the state returns to 0 with the grant still 0, and the grant appears only one edge later. The bench checks that order as well.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH_A = 3'd0,
        ST_FETCH_B = 3'd1,
        ST_FETCH_C = 3'd2,
        ST_DECODE  = 3'd3,
        ST_EXEC    = 3'd4
    } bsq_state_e;

    typedef struct packed {
        bsq_state_e state;
        logic       grant;
    } bsq_regs_t;

endpackage

// File: rtl/bsq_fsm.sv
module bsq_fsm
    import bsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_req_i,
    input  logic       exec_done_i,
    output bsq_state_e state_o,
    output logic       grant_o,
    output logic       fetch_uop_o
);

    bsq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d      = regs_q;
        fetch_uop_o = 1'b0;
        unique case (regs_q.state)
            ST_FETCH_A: begin
                // bus request is only honoured here
                regs_d.grant = bus_req_i;
                if (!bus_req_i) begin
                    fetch_uop_o  = 1'b1;
                    regs_d.state = ST_FETCH_B;
                end
            end
            ST_FETCH_B: regs_d.state = ST_FETCH_C;
            ST_FETCH_C: regs_d.state = ST_DECODE;
            ST_DECODE:  regs_d.state = ST_EXEC;
            ST_EXEC: begin
                if (exec_done_i) begin
                    regs_d.state = ST_FETCH_A;
                end
            end
            default: begin
                regs_d.state = ST_FETCH_A;
                regs_d.grant = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.state <= ST_FETCH_A;
            regs_q.grant <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign state_o = regs_q.state;
    assign grant_o = regs_q.grant;

endmodule

// File: rtl/bsq_drv_en.sv
module bsq_drv_en #(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input  logic              grant_i,
    input  logic              mem_wr_i,
    output logic [ADDR_W-1:0] addr_oe_o,
    output logic [CTRL_W-1:0] ctrl_oe_o,
    output logic              data_oe_o
);

    logic drive_ok;

    assign drive_ok = ~grant_i;

    for (genvar a = 0; a < ADDR_W; a++) begin : g_addr_line
        assign addr_oe_o[a] = drive_ok;
    end

    for (genvar c = 0; c < CTRL_W; c++) begin : g_ctrl_line
        assign ctrl_oe_o[c] = drive_ok;
    end

    assign data_oe_o = drive_ok & mem_wr_i;

endmodule

// File: rtl/busgrant_sequencer.sv
module busgrant_sequencer
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req_i,
    input  logic                exec_done_i,
    input  logic                mem_wr_i,
    output logic                bus_grant_o,
    output logic [STATE_W-1:0]  state_o,
    output logic                fetch_uop_o,
    output logic [ADDR_W-1:0]   addr_oe_o,
    output logic [CTRL_W-1:0]   ctrl_oe_o,
    output logic                data_oe_o
);

    bsq_state_e state;
    logic       grant;

    bsq_fsm i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_req_i   (bus_req_i),
        .exec_done_i (exec_done_i),
        .state_o     (state),
        .grant_o     (grant),
        .fetch_uop_o (fetch_uop_o)
    );

    bsq_drv_en #(
        .ADDR_W (ADDR_W),
        .CTRL_W (CTRL_W)
    ) i_drv_en (
        .grant_i   (grant),
        .mem_wr_i  (mem_wr_i),
        .addr_oe_o (addr_oe_o),
        .ctrl_oe_o (ctrl_oe_o),
        .data_oe_o (data_oe_o)
    );

    assign state_o     = state;
    assign bus_grant_o = grant;

endmodule

// File: rtl/bsq_checker.sv
module bsq_checker
    import bsq_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CTRL_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req_i,
    input logic               exec_done_i,
    input logic               mem_wr_i,
    input logic               bus_grant_o,
    input logic [STATE_W-1:0] state_o,
    input logic               fetch_uop_o,
    input logic [ADDR_W-1:0]  addr_oe_o,
    input logic [CTRL_W-1:0]  ctrl_oe_o,
    input logic               data_oe_o
);

    p_grant_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && bus_req_i) |=> (bus_grant_o && state_o == 3'd0));

    p_no_uop_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && bus_req_i) |-> !fetch_uop_o);

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !bus_req_i) |=> (!bus_grant_o && state_o == 3'd1));

    p_exec_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && !exec_done_i) |=> state_o == 3'd4);

    p_no_grant_midinstr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o != 3'd0) |-> !bus_grant_o);

    p_buses_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant_o |-> (addr_oe_o == '0 && ctrl_oe_o == '0));

    p_data_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant_o |-> !data_oe_o);

endmodule

bind busgrant_sequencer bsq_checker #(
    .ADDR_W (ADDR_W),
    .CTRL_W (CTRL_W)
) i_bsq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_i   (bus_req_i),
    .exec_done_i (exec_done_i),
    .mem_wr_i    (mem_wr_i),
    .bus_grant_o (bus_grant_o),
    .state_o     (state_o),
    .fetch_uop_o (fetch_uop_o),
    .addr_oe_o   (addr_oe_o),
    .ctrl_oe_o   (ctrl_oe_o),
    .data_oe_o   (data_oe_o)
);

// File: tb/test_busgrant_sequencer.sv
`timescale 1ns/1ps
module test_busgrant_sequencer;

    localparam int ADDR_W = 16;
    localparam int CTRL_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req_i = 1'b0;
    logic              exec_done_i = 1'b0;
    logic              mem_wr_i = 1'b0;
    logic              bus_grant_o;
    logic [2:0]        state_o;
    logic              fetch_uop_o;
    logic [ADDR_W-1:0] addr_oe_o;
    logic [CTRL_W-1:0] ctrl_oe_o;
    logic              data_oe_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    busgrant_sequencer #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) i_busgrant_sequencer (
        .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .exec_done_i(exec_done_i),
        .mem_wr_i(mem_wr_i), .bus_grant_o(bus_grant_o), .state_o(state_o),
        .fetch_uop_o(fetch_uop_o), .addr_oe_o(addr_oe_o), .ctrl_oe_o(ctrl_oe_o),
        .data_oe_o(data_oe_o)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_enables(input string tag, input bit granted);
        chk({tag, " addr_oe"}, addr_oe_o, granted ? 0 : {ADDR_W{1'b1}});
        chk({tag, " ctrl_oe"}, ctrl_oe_o, granted ? 0 : {CTRL_W{1'b1}});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 state", state_o, 0);
        chk("R1 grant", bus_grant_o, 0);
        chk_enables("R1", 1'b0);
        rst_n = 1'b1;
    endtask

    // request held in first fetch, then dropped
    task automatic t_grant_hold();
        chk("R1 state after reset", state_o, 0);
        bus_req_i = 1'b1;
        #1;
        chk("R8 grant before edge", bus_grant_o, 0);
        chk("R3 strobe low", fetch_uop_o, 0);
        @(negedge clk);
        chk("R2 grant", bus_grant_o, 1);
        chk("R2 state", state_o, 0);
        chk_enables("R9 granted", 1'b1);
        mem_wr_i = 1'b1;
        #1;
        chk("R10 data off", data_oe_o, 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R3 state held", state_o, 0);
            chk("R3 strobe held low", fetch_uop_o, 0);
        end
        bus_req_i = 1'b0;
        mem_wr_i  = 1'b0;
        #1;
        chk("R8 grant kept till edge", bus_grant_o, 1);
        chk("R4 strobe", fetch_uop_o, 1);
        @(negedge clk);
        chk("R4 grant cleared", bus_grant_o, 0);
        chk("R4 state", state_o, 1);
        chk_enables("R9 released", 1'b0);
    endtask

    // walk through the instruction with execute stall
    task automatic t_sequence();
        @(negedge clk);
        chk("R5 fetch c", state_o, 2);
        @(negedge clk);
        chk("R5 decode", state_o, 3);
        @(negedge clk);
        chk("R5 exec", state_o, 4);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R6 exec wait", state_o, 4);
        end
        mem_wr_i = 1'b1;
        #1;
        chk("R10 data follows wr", data_oe_o, 1);
        exec_done_i = 1'b1;
        @(negedge clk);
        chk("R6 back to fetch", state_o, 0);
        exec_done_i = 1'b0;
        mem_wr_i    = 1'b0;
    endtask

    // request raised in the middle of an instruction
    task automatic t_mid_request();
        @(negedge clk);
        chk("R4 state", state_o, 1);
        bus_req_i = 1'b1;
        for (int s = 2; s <= 4; s++) begin
            @(negedge clk);
            chk("R7 state advances", state_o, s);
            chk("R7 no grant", bus_grant_o, 0);
            chk_enables("R7", 1'b0);
        end
        exec_done_i = 1'b1;
        @(negedge clk);
        exec_done_i = 1'b0;
        chk("R7 state fetch", state_o, 0);
        chk("R7 grant not yet", bus_grant_o, 0);
        @(negedge clk);
        chk("R2 late grant", bus_grant_o, 1);
        chk("R2 state held", state_o, 0);
        bus_req_i = 1'b0;
        @(negedge clk);
        chk("R4 late release", bus_grant_o, 0);
        chk("R4 late state", state_o, 1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_grant_hold();
        t_sequence();
        t_mid_request();
        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule